// File: doc/BRIEF.md
# Shared Address and Loop Sequencer

This block generates memory addresses and loop control once, centrally, for a linear chain of identical processing cells that all follow the same data-independent addressing pattern. In each cycle it takes a decoded control word. From that word it can issue up to two addresses, change up to two address registers, step a loop counter and report loop termination. The addresses it issues leave on one address channel toward the first cell, together with a small group of systolic control bits. The control bits travel down the chain alongside the addresses.

Each of the two address lanes picks its own source. The source can be an address register, a register plus an offset from the control word, a constant taken straight from the control word, or an entry of a 256-entry address table. A table entry is indexed by the low eight bits of a register. The table is filled through a simple write port while the sequencer is stopped, which makes patterns such as bit-reversed FFT orders cheap. All address arithmetic is 16-bit integer arithmetic that wraps modulo 2^16.

Top module: `addr_loop_seq`

## Requirements
- R1: After reset, both lane valids, both lane addresses, the channel control bits, the loop count and the done flag are zero, and every address register reads as zero.
- R2: While `run` is high with a lane enabled and source code 0, that lane issues the value of the selected register on the clock edge that follows.
- R3: Source code 1 issues the selected register plus the lane offset, wrapping modulo 2^16.
- R4: Source code 2 issues the table entry indexed by bits [7:0] of the selected register. Source code 3 issues the lane offset directly.
- R5: Both lanes work independently in the same cycle, and each has its own valid.
- R6: An update slot with op 0 loads its value into the selected register, and op 1 adds its value to it. The new value becomes visible to address reads only in the next cycle. A read in the same cycle returns the old value.
- R7: When both update slots target the same register in one cycle, slot 1's result is kept.
- R8: The loop counter loads the immediate, and the load takes priority over a decrement. A decrement reduces a nonzero count by one. The done flag is high only in the cycle in which a decrement brings the count to zero. A decrement at zero leaves the count at zero and keeps done low.
- R9: While `run` is low, both valids are low and the registers and loop counter do not change.
- R10: A table write is accepted only while `run` is low, and its value can be read in the following cycle. A write attempted while `run` is high leaves the entry unchanged.
- R11: `ch_ctrl` carries `sys_ctrl` from the previous cycle while `run` was high in that cycle, and it is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Execution enable; also locks the table |
| pa_en | input | 1 | Lane A issue enable |
| pa_src | input | 2 | Lane A source code |
| pa_reg | input | 2 | Lane A register select |
| pa_ofs | input | 16 | Lane A offset / direct value |
| pb_en | input | 1 | Lane B issue enable |
| pb_src | input | 2 | Lane B source code |
| pb_reg | input | 2 | Lane B register select |
| pb_ofs | input | 16 | Lane B offset / direct value |
| u0_en | input | 1 | Update slot 0 enable |
| u0_op | input | 1 | Slot 0 op: 0 load, 1 add |
| u0_reg | input | 2 | Slot 0 target register |
| u0_val | input | 16 | Slot 0 operand |
| u1_en | input | 1 | Update slot 1 enable |
| u1_op | input | 1 | Slot 1 op: 0 load, 1 add |
| u1_reg | input | 2 | Slot 1 target register |
| u1_val | input | 16 | Slot 1 operand |
| lp_load | input | 1 | Load loop counter |
| lp_init | input | 16 | Loop counter immediate |
| lp_dec | input | 1 | Decrement loop counter |
| sys_ctrl | input | 4 | Systolic control bits to forward |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 8 | Table write index |
| tbl_data | input | 16 | Table write data |
| ch_a_vld | output | 1 | Lane A address valid |
| ch_a | output | 16 | Lane A address |
| ch_b_vld | output | 1 | Lane B address valid |
| ch_b | output | 16 | Lane B address |
| ch_ctrl | output | 4 | Forwarded control bits |
| loop_cnt | output | 16 | Current loop count |
| loop_done | output | 1 | Loop reached zero this cycle |

## Verification
The hardest case to reach is a cycle in which a register is read and written at once. The same cycle also carries a write collision from both slots, or a table write attempted during execution. None of these leaves a trace at the ports unless a later read happens to fetch the affected value. The stimulus therefore pairs each such cycle with a follow-up read on a lane. For the refused table write, the follow-up is a table-sourced read through a register that points at the entry. The loop corner is reached by counting down from a small immediate through zero and issuing one more decrement there.

// File: rtl/addr_seq_pkg.sv
package addr_seq_pkg;
    typedef enum logic [1:0] {
        SRC_REG    = 2'd0,
        SRC_STRIDE = 2'd1,
        SRC_TABLE  = 2'd2,
        SRC_DIRECT = 2'd3
    } src_e;

    typedef enum logic {
        UPD_LOAD = 1'b0,
        UPD_ADD  = 1'b1
    } upd_e;
endpackage

// File: rtl/addr_seq_regfile.sv
module addr_seq_regfile #(
    parameter int NREG = 4,
    parameter int AW   = 16,
    parameter int NUPD = 2,
    localparam int RIW = $clog2(NREG)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run,
    input  logic [NUPD-1:0]                upd_en,
    input  logic [NUPD-1:0]                upd_op,
    input  logic [NUPD-1:0][RIW-1:0]       upd_reg,
    input  logic [NUPD-1:0][AW-1:0]        upd_val,
    output logic [NREG-1:0][AW-1:0]        regs_o
);
    import addr_seq_pkg::*;

    typedef struct packed {
        logic [NREG-1:0][AW-1:0] regs;
    } rf_s;

    rf_s st_d, st_q;

    // Later slots overwrite earlier ones; adds use the pre-update value.
    always_comb begin
        st_d = st_q;
        if (run) begin
            for (int s = 0; s < NUPD; s++) begin
                if (upd_en[s]) begin
                    if (upd_e'(upd_op[s]) == UPD_ADD)
                        st_d.regs[upd_reg[s]] = st_q.regs[upd_reg[s]] + upd_val[s];
                    else
                        st_d.regs[upd_reg[s]] = upd_val[s];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o = st_q.regs;
endmodule

// File: rtl/addr_seq_table.sv
module addr_seq_table #(
    parameter int DEPTH = 256,
    parameter int AW    = 16,
    parameter int NRD   = 2,
    localparam int TIW  = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     we,
    input  logic [TIW-1:0]           widx,
    input  logic [AW-1:0]            wdata,
    input  logic [NRD-1:0][TIW-1:0]  ridx,
    output logic [NRD-1:0][AW-1:0]   rdata
);
    logic [DEPTH-1:0][AW-1:0] mem_d, mem_q;

    // Writes are locked out during execution.
    always_comb begin
        mem_d = mem_q;
        if (we && !run) mem_d[widx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = mem_q[ridx[g]];
    end
endmodule

// File: rtl/addr_seq_loop.sv
module addr_seq_loop #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          load,
    input  logic [CW-1:0] init,
    input  logic          dec,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          done;
    } lp_s;

    lp_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (run) begin
            if (load) begin
                st_d.cnt = init;
            end else if (dec && (st_q.cnt != '0)) begin
                st_d.cnt  = st_q.cnt - 1'b1;
                st_d.done = (st_q.cnt == CW'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign done_o = st_q.done;
endmodule

// File: rtl/addr_seq_port.sv
module addr_seq_port #(
    parameter int NREG  = 4,
    parameter int AW    = 16,
    parameter int DEPTH = 256,
    localparam int RIW  = $clog2(NREG),
    localparam int TIW  = $clog2(DEPTH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    en,
    input  logic [1:0]              src,
    input  logic [RIW-1:0]          rsel,
    input  logic [AW-1:0]           ofs,
    input  logic [NREG-1:0][AW-1:0] regs,
    output logic [TIW-1:0]          tbl_ridx,
    input  logic [AW-1:0]           tbl_rdata,
    output logic                    vld_o,
    output logic [AW-1:0]           addr_o
);
    import addr_seq_pkg::*;

    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
    } pt_s;

    pt_s           st_d, st_q;
    logic [AW-1:0] base;
    logic [AW-1:0] pick;

    assign base     = regs[rsel];
    assign tbl_ridx = base[TIW-1:0];

    always_comb begin
        unique case (src_e'(src))
            SRC_REG:    pick = base;
            SRC_STRIDE: pick = base + ofs;
            SRC_TABLE:  pick = tbl_rdata;
            default:    pick = ofs;
        endcase
    end

    always_comb begin
        st_d = '0;
        if (run && en) begin
            st_d.vld  = 1'b1;
            st_d.addr = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o  = st_q.vld;
    assign addr_o = st_q.addr;
endmodule

// File: rtl/addr_loop_seq.sv
module addr_loop_seq #(
    parameter int NREG  = 4,
    parameter int AW    = 16,
    parameter int DEPTH = 256,
    parameter int CW    = 16,
    parameter int CTLW  = 4,
    localparam int RIW  = $clog2(NREG),
    localparam int TIW  = $clog2(DEPTH),
    localparam int NLN  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            pa_en,
    input  logic [1:0]      pa_src,
    input  logic [RIW-1:0]  pa_reg,
    input  logic [AW-1:0]   pa_ofs,
    input  logic            pb_en,
    input  logic [1:0]      pb_src,
    input  logic [RIW-1:0]  pb_reg,
    input  logic [AW-1:0]   pb_ofs,
    input  logic            u0_en,
    input  logic            u0_op,
    input  logic [RIW-1:0]  u0_reg,
    input  logic [AW-1:0]   u0_val,
    input  logic            u1_en,
    input  logic            u1_op,
    input  logic [RIW-1:0]  u1_reg,
    input  logic [AW-1:0]   u1_val,
    input  logic            lp_load,
    input  logic [CW-1:0]   lp_init,
    input  logic            lp_dec,
    input  logic [CTLW-1:0] sys_ctrl,
    input  logic            tbl_we,
    input  logic [TIW-1:0]  tbl_idx,
    input  logic [AW-1:0]   tbl_data,
    output logic            ch_a_vld,
    output logic [AW-1:0]   ch_a,
    output logic            ch_b_vld,
    output logic [AW-1:0]   ch_b,
    output logic [CTLW-1:0] ch_ctrl,
    output logic [CW-1:0]   loop_cnt,
    output logic            loop_done
);
    logic [NREG-1:0][AW-1:0] regs;
    logic [NLN-1:0]          ln_en, ln_vld;
    logic [NLN-1:0][1:0]     ln_src;
    logic [NLN-1:0][RIW-1:0] ln_reg;
    logic [NLN-1:0][AW-1:0]  ln_ofs, ln_addr, ln_tdata;
    logic [NLN-1:0][TIW-1:0] ln_tidx;

    assign ln_en  = {pb_en, pa_en};
    assign ln_src = {pb_src, pa_src};
    assign ln_reg = {pb_reg, pa_reg};
    assign ln_ofs = {pb_ofs, pa_ofs};

    addr_seq_regfile #(.NREG(NREG), .AW(AW), .NUPD(2)) u_rf (
        .clk(clk), .rst_n(rst_n), .run(run),
        .upd_en ({u1_en,  u0_en}),
        .upd_op ({u1_op,  u0_op}),
        .upd_reg({u1_reg, u0_reg}),
        .upd_val({u1_val, u0_val}),
        .regs_o (regs)
    );

    addr_seq_table #(.DEPTH(DEPTH), .AW(AW), .NRD(NLN)) u_tbl (
        .clk(clk), .rst_n(rst_n), .run(run),
        .we(tbl_we), .widx(tbl_idx), .wdata(tbl_data),
        .ridx(ln_tidx), .rdata(ln_tdata)
    );

    for (genvar g = 0; g < NLN; g++) begin : g_lane
        addr_seq_port #(.NREG(NREG), .AW(AW), .DEPTH(DEPTH)) u_port (
            .clk(clk), .rst_n(rst_n), .run(run),
            .en(ln_en[g]), .src(ln_src[g]), .rsel(ln_reg[g]), .ofs(ln_ofs[g]),
            .regs(regs),
            .tbl_ridx(ln_tidx[g]), .tbl_rdata(ln_tdata[g]),
            .vld_o(ln_vld[g]), .addr_o(ln_addr[g])
        );
    end

    addr_seq_loop #(.CW(CW)) u_loop (
        .clk(clk), .rst_n(rst_n), .run(run),
        .load(lp_load), .init(lp_init), .dec(lp_dec),
        .cnt_o(loop_cnt), .done_o(loop_done)
    );

    typedef struct packed {
        logic [CTLW-1:0] ctrl;
    } top_s;

    top_s st_d, st_q;

    always_comb begin
        st_d.ctrl = run ? sys_ctrl : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ch_ctrl  = st_q.ctrl;
    assign ch_a_vld = ln_vld[0];
    assign ch_a     = ln_addr[0];
    assign ch_b_vld = ln_vld[1];
    assign ch_b     = ln_addr[1];
endmodule

// File: rtl/addr_seq_checker.sv
module addr_seq_checker #(
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int CTLW = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            run,
    input logic            pa_en,
    input logic [1:0]      pa_src,
    input logic [AW-1:0]   pa_ofs,
    input logic            lp_load,
    input logic            lp_dec,
    input logic            ch_a_vld,
    input logic [AW-1:0]   ch_a,
    input logic            ch_b_vld,
    input logic [CTLW-1:0] ch_ctrl,
    input logic [CW-1:0]   loop_cnt,
    input logic            loop_done
);
    assert_valid_needs_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_a_vld || ch_b_vld) |-> $past(run));

    assert_idle_loop_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(loop_cnt));

    assert_done_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |-> (loop_cnt == '0));

    assert_done_from_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        loop_done |-> ($past(loop_cnt) == CW'(1)));

    assert_dec_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && lp_dec && !lp_load && loop_cnt != '0) |=> (loop_cnt == $past(loop_cnt) - CW'(1)));

    assert_ctrl_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (ch_ctrl == '0));

    assert_direct_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && pa_en && pa_src == 2'd3) |=> (ch_a_vld && ch_a == $past(pa_ofs)));
endmodule

bind addr_loop_seq addr_seq_checker #(.AW(AW), .CW(CW), .CTLW(CTLW)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .pa_en(pa_en), .pa_src(pa_src), .pa_ofs(pa_ofs),
    .lp_load(lp_load), .lp_dec(lp_dec),
    .ch_a_vld(ch_a_vld), .ch_a(ch_a), .ch_b_vld(ch_b_vld),
    .ch_ctrl(ch_ctrl), .loop_cnt(loop_cnt), .loop_done(loop_done)
);

// File: tb/sim_addr_loop_seq.sv
module sim_addr_loop_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run;
    logic pa_en, pb_en, u0_en, u1_en, u0_op, u1_op, lp_load, lp_dec, tbl_we;
    logic [1:0] pa_src, pb_src, pa_reg, pb_reg, u0_reg, u1_reg;
    logic [15:0] pa_ofs, pb_ofs, u0_val, u1_val, lp_init, tbl_data;
    logic [3:0] sys_ctrl;
    logic [7:0] tbl_idx;
    logic ch_a_vld, ch_b_vld, loop_done;
    logic [15:0] ch_a, ch_b, loop_cnt;
    logic [3:0] ch_ctrl;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    addr_loop_seq u0 (.*);

    function automatic logic [15:0] tbl_pat(int i);
        return 16'h3C00 + 16'(i * 7);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_in();
        run = 1'b1; pa_en = 0; pb_en = 0; u0_en = 0; u1_en = 0; u0_op = 0; u1_op = 0;
        lp_load = 0; lp_dec = 0; tbl_we = 0;
        pa_src = 0; pb_src = 0; pa_reg = 0; pb_reg = 0; u0_reg = 0; u1_reg = 0;
        pa_ofs = 0; pb_ofs = 0; u0_val = 0; u1_val = 0; lp_init = 0; tbl_data = 0;
        sys_ctrl = 0; tbl_idx = 0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic read_a(logic [1:0] src, logic [1:0] r, logic [15:0] ofs);
        clear_in();
        pa_en = 1; pa_src = src; pa_reg = r; pa_ofs = ofs;
        step();
    endtask

    task automatic t_reset();
        chk("R1 a_vld", 32'(ch_a_vld), 0);
        chk("R1 b_vld", 32'(ch_b_vld), 0);
        chk("R1 a", 32'(ch_a), 0);
        chk("R1 ctrl", 32'(ch_ctrl), 0);
        chk("R1 cnt", 32'(loop_cnt), 0);
        chk("R1 done", 32'(loop_done), 0);
        read_a(2'd0, 2'd3, 16'h0);
        chk("R1 reg3 zero", 32'(ch_a), 0);
    endtask

    task automatic t_table_load();
        for (int i = 0; i < 16; i++) begin
            clear_in(); run = 0; tbl_we = 1; tbl_idx = 8'(i); tbl_data = tbl_pat(i);
            step();
        end
    endtask

    task automatic t_reg_stride();
        clear_in();
        u0_en = 1; u0_reg = 1; u0_val = 16'h0010;
        u1_en = 1; u1_reg = 2; u1_val = 16'hFFF0;
        step();
        clear_in();
        pa_en = 1; pa_src = 0; pa_reg = 1;
        pb_en = 1; pb_src = 1; pb_reg = 2; pb_ofs = 16'h0020;
        step();
        chk("R2 reg src", 32'(ch_a), 32'h0010);
        chk("R5 a valid", 32'(ch_a_vld), 1);
        chk("R3 stride wrap", 32'(ch_b), 32'h0010);
        chk("R5 b valid", 32'(ch_b_vld), 1);
    endtask

    task automatic t_read_during_write();
        clear_in();
        pa_en = 1; pa_src = 0; pa_reg = 1;
        u0_en = 1; u0_op = 1; u0_reg = 1; u0_val = 16'h0004;
        step();
        chk("R6 old value", 32'(ch_a), 32'h0010);
        read_a(2'd0, 2'd1, 16'h0);
        chk("R6 add visible", 32'(ch_a), 32'h0014);
    endtask

    task automatic t_collision();
        clear_in();
        u0_en = 1; u0_reg = 3; u0_val = 16'h1111;
        u1_en = 1; u1_reg = 3; u1_val = 16'h2222;
        step();
        read_a(2'd0, 2'd3, 16'h0);
        chk("R7 slot1 wins", 32'(ch_a), 32'h2222);
    endtask

    task automatic t_table_direct();
        clear_in();
        u0_en = 1; u0_reg = 1; u0_val = 16'h0105;
        step();
        clear_in();
        pa_en = 1; pa_src = 2; pa_reg = 1;
        pb_en = 1; pb_src = 3; pb_ofs = 16'hBEEF;
        step();
        chk("R4 table src", 32'(ch_a), 32'(tbl_pat(5)));
        chk("R4 direct src", 32'(ch_b), 32'hBEEF);
    endtask

    task automatic t_table_lock();
        clear_in(); tbl_we = 1; tbl_idx = 5; tbl_data = 16'hDEAD;
        step();
        read_a(2'd2, 2'd1, 16'h0);
        chk("R10 write refused", 32'(ch_a), 32'(tbl_pat(5)));
        clear_in(); run = 0; tbl_we = 1; tbl_idx = 5; tbl_data = 16'hDEAD;
        step();
        read_a(2'd2, 2'd1, 16'h0);
        chk("R10 write accepted", 32'(ch_a), 32'hDEAD);
    endtask

    task automatic t_loop();
        clear_in(); lp_load = 1; lp_init = 16'd3;
        step();
        chk("R8 load", 32'(loop_cnt), 3);
        for (int k = 2; k >= 0; k--) begin
            clear_in(); lp_dec = 1;
            step();
            chk("R8 count", 32'(loop_cnt), 32'(k));
            chk("R8 done", 32'(loop_done), (k == 0) ? 1 : 0);
        end
        clear_in();
        step();
        chk("R8 done pulse", 32'(loop_done), 0);
        clear_in(); lp_dec = 1;
        step();
        chk("R8 dec at zero cnt", 32'(loop_cnt), 0);
        chk("R8 dec at zero done", 32'(loop_done), 0);
        clear_in(); lp_load = 1; lp_init = 16'd5; lp_dec = 1;
        step();
        chk("R8 load priority", 32'(loop_cnt), 5);
    endtask

    task automatic t_idle();
        clear_in(); u0_en = 1; u0_reg = 0; u0_val = 16'h0ABC;
        step();
        clear_in(); run = 0;
        pa_en = 1; pa_src = 3; pa_ofs = 16'h1234;
        pb_en = 1; pb_src = 3; pb_ofs = 16'h4321;
        u0_en = 1; u0_reg = 0; u0_val = 16'h7777;
        lp_load = 1; lp_init = 16'd9; sys_ctrl = 4'hF;
        step();
        chk("R9 a idle", 32'(ch_a_vld), 0);
        chk("R9 b idle", 32'(ch_b_vld), 0);
        chk("R11 ctrl idle", 32'(ch_ctrl), 0);
        chk("R9 loop held", 32'(loop_cnt), 5);
        read_a(2'd0, 2'd0, 16'h0);
        chk("R9 reg held", 32'(ch_a), 32'h0ABC);
    endtask

    task automatic t_ctrl();
        clear_in(); sys_ctrl = 4'h5;
        step();
        chk("R11 ctrl fwd", 32'(ch_ctrl), 5);
        clear_in(); sys_ctrl = 4'hA;
        step();
        chk("R11 ctrl fwd2", 32'(ch_ctrl), 32'hA);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_in();
        run = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        t_reset();
        t_table_load();
        t_reg_stride();
        t_read_during_write();
        t_collision();
        t_table_direct();
        t_table_lock();
        t_loop();
        t_idle();
        t_ctrl();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule